// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block decodes the write side of a parallel NOR flash that uses the two-cycle unlock command protocol. It watches bus write strobes, each carrying a byte address and a data word. It steps through the unlock cycles, the command cycle and the data cycles, and it acts on a small on-chip array. The supported actions are: program one word, erase one sector, and erase the whole chip. A read port on the array and a mode output let the surrounding read path choose between array data, identification data and query data.

A write counts as a command only through the low byte of its data. The address is turned into a word offset within its sector (byte address divided by the device width). The unlock and command checks then use that offset. Programming takes effect at once. An erase runs for a parameterised number of clocks. During that time the block rewrites one array word per clock to all ones, and then it pulses a done flag. An unlock-bypass mode removes the two unlock cycles from every later command until it is left.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset the mode output reads 0 (array read), the bypass flag is 0 and the erase busy and done flags are 0.
- R2: The unlock takes two writes in a row: 0xAA at word offset 0x555, then 0x55 at word offset 0x2AA. Any write that does not match the expected pair returns the sequencer to array read, and a later program data write then has no effect on the array.
- R3: On the cycle after the unlock, and only at word offset 0x555, the command byte selects the next step. 0xA0 selects program (mode 2). 0x90 selects autoselect (mode 1). 0x80 selects erase setup. 0x20 selects unlock bypass. Any other byte, or any other offset, returns to array read.
- R4: Writing 0xF0 returns to array read and clears bypass, from every state except two: the program data cycle, where 0xF0 is ordinary data, and a running erase.
- R5: Writing 0x98 at word offset 0x55 enters query mode (mode 4), either from array read or from autoselect. Any write while in query mode returns to array read and clears bypass.
- R6: The program data write ANDs the full data word into the addressed array word, so bits can only go from 1 to 0. The sequencer then leaves the program mode on the next cycle.
- R7: After 0x80 comes a second unlock pair. The sixth write then selects the erase. 0x10 at offset 0x555 sets every array word to all ones. 0x30 at any address sets every word of that address's sector to all ones and leaves the other sectors unchanged. Any other write returns to array read.
- R8: A sector erase holds the busy flag and mode 3 for SECT_ERASE_CYC clocks, and a chip erase holds them for ten times that. Once busy falls, the done flag is high for one clock while the mode is still 3. On the next clock the sequencer returns to array read, or to the command cycle if bypass is set. Writes made during the busy period have no effect.
- R9: In bypass mode the bypass flag is 1 and the command cycle accepts any offset. A program data write returns straight to the command cycle. From autoselect, a write of 0x00 leaves bypass and returns to array read.
- R10: The word offset is the byte address shifted right by log2(DEV_BYTES), taken modulo the sector size, so sector bits above the offset do not affect the unlock checks.
- R11: The read data output shows the array word at rd_addr one clock after rd_addr is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one write per high cycle |
| wr_addr | input | log2(SECT_WORDS*SECTORS*DEV_BYTES) | Byte address of the write |
| wr_data | input | 8*DEV_BYTES | Write data; the low byte is the command code |
| rd_addr | input | log2(SECT_WORDS*SECTORS) | Word index for the array read port |
| rd_data | output | 8*DEV_BYTES | Array word, one clock after rd_addr |
| mode_o | output | 3 | 0 array, 1 autoselect, 2 program, 3 erase, 4 query |
| bypass_o | output | 1 | Unlock bypass active |
| erase_busy_o | output | 1 | Erase timer running |
| erase_done_o | output | 1 | One-clock pulse when the erase timer expires |

## Verification
Most sequencer states (the two unlock steps, the command cycle and the three erase setup steps) all show mode 0. A wrong internal step therefore stays hidden until the write that should finish the sequence. It then appears at mode_o or bypass_o one clock after that write, or at rd_data one further clock after the programmed word is read. A wrong erase timer count appears at the clock where erase_busy_o falls. A wrong fill range appears at the first read of a word just inside or just outside the target sector. For these reasons the reference model is compared with mode, bypass, busy, done and read data on every clock, and the directed sequences always close with a command write or a read-back that brings out the hidden state.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [2:0] {
    MODE_ARRAY   = 3'd0,
    MODE_AUTOSEL = 3'd1,
    MODE_PROG    = 3'd2,
    MODE_ERASE   = 3'd3,
    MODE_QUERY   = 3'd4
  } nor_mode_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_UNL1, ST_CMD, ST_PROG, ST_AUTO,
    ST_EUNL0, ST_EUNL1, ST_ESEL, ST_BUSY, ST_QUERY
  } nor_state_e;

  localparam logic [7:0] CD_KEY0    = 8'hAA;
  localparam logic [7:0] CD_KEY1    = 8'h55;
  localparam logic [7:0] CD_ESETUP  = 8'h80;
  localparam logic [7:0] CD_AUTOSEL = 8'h90;
  localparam logic [7:0] CD_PROG    = 8'hA0;
  localparam logic [7:0] CD_BYPASS  = 8'h20;
  localparam logic [7:0] CD_ABORT   = 8'hF0;
  localparam logic [7:0] CD_QUERY   = 8'h98;
  localparam logic [7:0] CD_CHIP    = 8'h10;
  localparam logic [7:0] CD_SECTOR  = 8'h30;

  localparam int unsigned OFS_KEY0  = 32'h555;
  localparam int unsigned OFS_KEY1  = 32'h2AA;
  localparam int unsigned OFS_QUERY = 32'h55;

endpackage

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
  import nor_seq_pkg::*;
#(
  parameter int OFF_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] wr_off,
  input  logic [7:0]       wr_cmd,
  input  logic             erase_done,
  output nor_mode_e        mode,
  output logic             bypass,
  output logic             prog_we,
  output logic             erase_start,
  output logic             erase_chip
);

  localparam logic [OFF_W-1:0] K0 = OFF_W'(OFS_KEY0);
  localparam logic [OFF_W-1:0] K1 = OFF_W'(OFS_KEY1);
  localparam logic [OFF_W-1:0] KQ = OFF_W'(OFS_QUERY);

  nor_state_e st_q, st_d;
  logic       byp_q, byp_d;

  logic at_k0, hit_key0, hit_key1, hit_query;
  assign at_k0     = (wr_off == K0);
  assign hit_key0  = at_k0 && (wr_cmd == CD_KEY0);
  assign hit_key1  = (wr_off == K1) && (wr_cmd == CD_KEY1);
  assign hit_query = (wr_off == KQ) && (wr_cmd == CD_QUERY);

  always_comb begin
    st_d        = st_q;
    byp_d       = byp_q;
    prog_we     = 1'b0;
    erase_start = 1'b0;
    erase_chip  = 1'b0;
    if (st_q == ST_BUSY) begin
      if (erase_done) st_d = byp_q ? ST_CMD : ST_IDLE;
    end else if (wr_en) begin
      if (wr_cmd == CD_ABORT && st_q != ST_PROG) begin
        st_d  = ST_IDLE;
        byp_d = 1'b0;
      end else begin
        st_d  = ST_IDLE;
        byp_d = 1'b0;
        unique case (st_q)
          ST_IDLE: begin
            if (hit_query)     st_d = ST_QUERY;
            else if (hit_key0) st_d = ST_UNL1;
          end
          ST_UNL1:  if (hit_key1) st_d = ST_CMD;
          ST_CMD: begin
            if (byp_q || at_k0) begin
              byp_d = byp_q;
              unique case (wr_cmd)
                CD_BYPASS:  begin st_d = ST_CMD; byp_d = 1'b1; end
                CD_ESETUP:  st_d = ST_EUNL0;
                CD_AUTOSEL: st_d = ST_AUTO;
                CD_PROG:    st_d = ST_PROG;
                default:    begin st_d = ST_IDLE; byp_d = 1'b0; end
              endcase
            end
          end
          ST_PROG: begin
            prog_we = 1'b1;
            byp_d   = byp_q;
            st_d    = byp_q ? ST_CMD : ST_IDLE;
          end
          ST_AUTO: begin
            if (hit_query) begin st_d = ST_QUERY; byp_d = byp_q; end
          end
          ST_EUNL0: if (hit_key0) begin st_d = ST_EUNL1; byp_d = byp_q; end
          ST_EUNL1: if (hit_key1) begin st_d = ST_ESEL;  byp_d = byp_q; end
          ST_ESEL: begin
            if (wr_cmd == CD_CHIP && at_k0) begin
              st_d = ST_BUSY; byp_d = byp_q; erase_start = 1'b1; erase_chip = 1'b1;
            end else if (wr_cmd == CD_SECTOR) begin
              st_d = ST_BUSY; byp_d = byp_q; erase_start = 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      byp_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      byp_q <= byp_d;
    end
  end

  always_comb begin
    unique case (st_q)
      ST_AUTO:  mode = MODE_AUTOSEL;
      ST_PROG:  mode = MODE_PROG;
      ST_BUSY:  mode = MODE_ERASE;
      ST_QUERY: mode = MODE_QUERY;
      default:  mode = MODE_ARRAY;
    endcase
  end

  assign bypass = byp_q;

endmodule

// File: rtl/nor_erase_timer.sv
module nor_erase_timer #(
  parameter int AW        = 12,
  parameter int OFF_W     = 11,
  parameter int SW        = 1,
  parameter int SECT_CYC  = 4096,
  parameter int CHIP_CYC  = 40960
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          chip,
  input  logic [SW-1:0] sect,
  output logic          busy,
  output logic          done,
  output logic          fill_we,
  output logic [AW-1:0] fill_addr
);

  localparam int CW = $clog2(CHIP_CYC + 1);
  localparam int RW = AW + 1;

  logic          busy_q, busy_d, done_q, done_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic [RW-1:0] rem_q, rem_d;
  logic          step_en;

  assign step_en = start || busy_q;

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    cnt_d  = cnt_q;
    ptr_d  = ptr_q;
    rem_d  = rem_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = chip ? CW'(CHIP_CYC - 1) : CW'(SECT_CYC - 1);
      ptr_d  = chip ? '0 : {sect, {OFF_W{1'b0}}};
      rem_d  = chip ? RW'(2 ** AW) : RW'(2 ** OFF_W);
    end else if (busy_q) begin
      if (rem_q != '0) begin
        ptr_d = ptr_q + 1'b1;
        rem_d = rem_q - 1'b1;
      end
      if (cnt_q == '0) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      ptr_q  <= '0;
      rem_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      if (step_en) begin
        cnt_q <= cnt_d;
        ptr_q <= ptr_d;
        rem_q <= rem_d;
      end
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign fill_we   = busy_q && (rem_q != '0);
  assign fill_addr = ptr_q;

endmodule

// File: rtl/nor_array.sv
module nor_array #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          prog_we,
  input  logic [AW-1:0] prog_addr,
  input  logic [DW-1:0] prog_data,
  input  logic          fill_we,
  input  logic [AW-1:0] fill_addr,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  localparam int WORDS = 2 ** AW;

  logic [DW-1:0] mem [WORDS];
  logic [DW-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (fill_we) begin
      mem[fill_addr] <= '1;
    end else if (prog_we) begin
      mem[prog_addr] <= mem[prog_addr] & prog_data;
    end
    rd_q <= mem[rd_addr];
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int DEV_BYTES      = 2,
  parameter int SECT_WORDS     = 2048,
  parameter int SECTORS        = 2,
  parameter int SECT_ERASE_CYC = 4096
) (
  input  logic                                                clk,
  input  logic                                                rst_n,
  input  logic                                                wr_en,
  input  logic [$clog2(SECT_WORDS*SECTORS*DEV_BYTES)-1:0]     wr_addr,
  input  logic [8*DEV_BYTES-1:0]                              wr_data,
  input  logic [$clog2(SECT_WORDS*SECTORS)-1:0]               rd_addr,
  output logic [8*DEV_BYTES-1:0]                              rd_data,
  output logic [2:0]                                          mode_o,
  output logic                                                bypass_o,
  output logic                                                erase_busy_o,
  output logic                                                erase_done_o
);

  localparam int DW       = 8 * DEV_BYTES;
  localparam int WAW      = $clog2(SECT_WORDS * SECTORS);
  localparam int BSH      = $clog2(DEV_BYTES);
  localparam int BAW      = WAW + BSH;
  localparam int OFF_W    = $clog2(SECT_WORDS);
  localparam int SW       = $clog2(SECTORS);
  localparam int CHIP_CYC = 10 * SECT_ERASE_CYC;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [WAW-1:0]   wr_word;
  logic [OFF_W-1:0] wr_off;
  logic [SW-1:0]    wr_sect;

  assign wr_word = wr_addr[BAW-1:BSH];
  assign wr_off  = wr_word[OFF_W-1:0];
  assign wr_sect = wr_word[WAW-1:OFF_W];

  if (BSH > 0) begin : g_lane
    logic unused_lane;
    assign unused_lane = ^wr_addr[BSH-1:0];
  end

  nor_mode_e      mode_w;
  logic           prog_we, erase_start, erase_chip;
  logic           busy_w, done_w, fill_we;
  logic [WAW-1:0] fill_addr;

  nor_cmd_fsm #(.OFF_W(OFF_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .wr_en       (wr_en),
    .wr_off      (wr_off),
    .wr_cmd      (wr_data[7:0]),
    .erase_done  (done_w),
    .mode        (mode_w),
    .bypass      (bypass_o),
    .prog_we     (prog_we),
    .erase_start (erase_start),
    .erase_chip  (erase_chip)
  );

  nor_erase_timer #(
    .AW       (WAW),
    .OFF_W    (OFF_W),
    .SW       (SW),
    .SECT_CYC (SECT_ERASE_CYC),
    .CHIP_CYC (CHIP_CYC)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (erase_start),
    .chip      (erase_chip),
    .sect      (wr_sect),
    .busy      (busy_w),
    .done      (done_w),
    .fill_we   (fill_we),
    .fill_addr (fill_addr)
  );

  nor_array #(.AW(WAW), .DW(DW)) u_array (
    .clk       (clk),
    .prog_we   (prog_we),
    .prog_addr (wr_word),
    .prog_data (wr_data),
    .fill_we   (fill_we),
    .fill_addr (fill_addr),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data)
  );

  assign mode_o       = mode_w;
  assign erase_busy_o = busy_w;
  assign erase_done_o = done_w;

endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk
  import nor_seq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_cmd,
  input logic [2:0] mode_o,
  input logic       bypass_o,
  input logic       erase_busy_o,
  input logic       erase_done_o
);

  AST_BUSY_IN_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    erase_busy_o |-> mode_o == MODE_ERASE); // R8

  AST_DONE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    erase_done_o |=> !erase_done_o); // R8

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(erase_done_o) |-> $past(erase_busy_o) && !erase_busy_o); // R8

  AST_ABORT_TO_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_cmd == CD_ABORT && mode_o != MODE_PROG && mode_o != MODE_ERASE)
    |=> (mode_o == MODE_ARRAY && !bypass_o)); // R4

  AST_QUERY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mode_o == MODE_QUERY) |=> (mode_o == MODE_ARRAY && !bypass_o)); // R5

  AST_PROG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mode_o == MODE_PROG) |=> mode_o == MODE_ARRAY); // R6

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o <= 3'd4); // R1

endmodule

bind nor_cmd_seq nor_cmd_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_cmd       (wr_data[7:0]),
  .mode_o       (mode_o),
  .bypass_o     (bypass_o),
  .erase_busy_o (erase_busy_o),
  .erase_done_o (erase_done_o)
);

// File: tb/sim_nor_cmd_seq.sv
`timescale 1ns/1ps
module sim_nor_cmd_seq;

  localparam int SW_WORDS = 2048;
  localparam int NSECT    = 2;
  localparam int NWORDS   = SW_WORDS * NSECT;
  localparam int SCYC     = 2100;
  localparam int CCYC     = 10 * SCYC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [12:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [11:0] rd_addr = '0;
  logic [15:0] rd_data;
  logic [2:0]  mode_o;
  logic        bypass_o, erase_busy_o, erase_done_o;

  always #2.5 clk = ~clk;

  nor_cmd_seq #(
    .DEV_BYTES(2), .SECT_WORDS(SW_WORDS), .SECTORS(NSECT), .SECT_ERASE_CYC(SCYC)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .mode_o(mode_o), .bypass_o(bypass_o),
    .erase_busy_o(erase_busy_o), .erase_done_o(erase_done_o)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit compare_on = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: state codes 0 idle,1 key1,2 cmd,3 prog,4 autosel,5 e-key0,6 e-key1,7 e-select,8 busy,9 query
  int m_st = 0, m_cnt = 0;
  bit m_byp = 0, m_busy = 0, m_done = 0;
  int m_mem [NWORDS];
  bit m_known [NWORDS];
  int m_rd = 0;
  bit m_rdk = 0;

  function automatic int exp_mode(int s);
    case (s)
      4: return 1;
      3: return 2;
      8: return 3;
      9: return 4;
      default: return 0;
    endcase
  endfunction

  task automatic m_idle();
    m_st = 0;
    m_byp = 0;
  endtask

  task automatic m_start(bit whole, int sect);
    int lo = whole ? 0 : sect * SW_WORDS;
    int n  = whole ? NWORDS : SW_WORDS;
    for (int i = lo; i < lo + n; i++) begin
      m_mem[i] = 16'hFFFF;
      m_known[i] = 1;
    end
    m_st = 8;
    m_busy = 1;
    m_cnt = (whole ? CCYC : SCYC) - 1;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_byp = 0; m_busy = 0; m_done = 0; m_cnt = 0;
    end else begin
      int o_st, wrd, woff, c;
      bit o_busy, o_done;
      o_st = m_st; o_busy = m_busy; o_done = m_done;
      m_rd  = m_mem[rd_addr];
      m_rdk = m_known[rd_addr];
      m_done = 0;
      if (o_busy) begin
        if (m_cnt == 0) begin m_busy = 0; m_done = 1; end
        else m_cnt--;
      end
      wrd  = int'(wr_addr) >> 1;
      woff = wrd % SW_WORDS;
      c    = int'(wr_data) & 8'hFF;
      if (o_st == 8) begin
        if (o_done) m_st = m_byp ? 2 : 0;
      end else if (wr_en) begin
        if (c == 8'hF0 && o_st != 3) m_idle();
        else begin
          case (o_st)
            0: if (woff == 'h55 && c == 'h98) m_st = 9;
               else if (woff == 'h555 && c == 'hAA) m_st = 1;
            1: if (woff == 'h2AA && c == 'h55) m_st = 2; else m_idle();
            2: if (!m_byp && woff != 'h555) m_idle();
               else if (c == 'h20) m_byp = 1;
               else if (c == 'h80) m_st = 5;
               else if (c == 'h90) m_st = 4;
               else if (c == 'hA0) m_st = 3;
               else m_idle();
            3: begin
                 m_mem[wrd] = m_mem[wrd] & int'(wr_data);
                 m_st = m_byp ? 2 : 0;
               end
            4: if (woff == 'h55 && c == 'h98) m_st = 9; else m_idle();
            5: if (woff == 'h555 && c == 'hAA) m_st = 6; else m_idle();
            6: if (woff == 'h2AA && c == 'h55) m_st = 7; else m_idle();
            7: if (c == 'h10 && woff == 'h555) m_start(1, 0);
               else if (c == 'h30) m_start(0, wrd / SW_WORDS);
               else m_idle();
            default: m_idle();
          endcase
        end
      end
    end
  end

  int busy_cycles = 0;
  always @(negedge clk) begin
    if (erase_busy_o) busy_cycles++;
    if (compare_on && !finished) begin
      chk("R2 mode", int'(mode_o), exp_mode(m_st));
      chk("R9 bypass", int'(bypass_o), int'(m_byp));
      chk("R8 busy", int'(erase_busy_o), int'(m_busy));
      chk("R8 done", int'(erase_done_o), int'(m_done));
      if (m_rdk && exp_mode(m_st) != 3) chk("R11 rd_data", int'(rd_data), m_rd);
    end
  end

  task automatic wrb(int baddr, int d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_addr = 13'(baddr);
    wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr(int w, int d);
    wrb(w << 1, d);
  endtask

  task automatic unlock();
    wr('h555, 'hAA);
    wr('h2AA, 'h55);
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk);
    rd_addr = 12'(a);
    @(negedge clk);
    v = int'(rd_data);
  endtask

  task automatic wait_erase();
    while (erase_busy_o) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    int v;
    for (int i = 0; i < NWORDS; i++) begin m_mem[i] = 0; m_known[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    compare_on = 1;
    // R1 reset state
    chk("R1 mode", int'(mode_o), 0);
    chk("R1 bypass", int'(bypass_o), 0);
    chk("R1 busy", int'(erase_busy_o), 0);

    // R7 chip erase, R8 its length
    unlock(); wr('h555, 'h80); unlock();
    busy_cycles = 0;
    wr('h555, 'h10);
    chk("R7 chip busy", int'(erase_busy_o), 1);
    chk("R8 erase mode", int'(mode_o), 3);
    wait_erase();
    chk("R8 chip length", busy_cycles, CCYC);
    chk("R8 done pulse", int'(erase_done_o), 1);
    chk("R8 mode at done", int'(mode_o), 3);
    @(negedge clk);
    chk("R8 back to array", int'(mode_o), 0);
    rd(0, v);      chk("R7 chip first", v, 'hFFFF);
    rd(4095, v);   chk("R7 chip last", v, 'hFFFF);

    // R3 program entry, R4 F0 as program data, R6 AND
    unlock(); wr('h555, 'hA0);
    chk("R3 program mode", int'(mode_o), 2);
    wr('h10, 'h12F0);
    chk("R6 leave program", int'(mode_o), 0);
    rd('h10, v);   chk("R4 F0 taken as data", v, 'h12F0);
    unlock(); wr('h555, 'hA0); wr('h10, 'hFF0F);
    rd('h10, v);   chk("R6 bits only clear", v, 'h1200);

    // R2 bad second unlock
    wr('h555, 'hAA); wr('h2AB, 'h55); wr('h555, 'hA0);
    chk("R2 no program", int'(mode_o), 0);
    wr('h20, 'h0000);
    rd('h20, v);   chk("R2 array untouched", v, 'hFFFF);

    // R3 bad command and bad command offset
    unlock(); wr('h555, 'h77);
    wr('h21, 'h0000);
    rd('h21, v);   chk("R3 unknown command", v, 'hFFFF);
    unlock(); wr('h554, 'hA0);
    chk("R3 wrong offset", int'(mode_o), 0);

    // R5 query from autoselect and from read
    unlock(); wr('h555, 'h90);
    chk("R3 autoselect", int'(mode_o), 1);
    wr('h55, 'h98);
    chk("R5 query from autosel", int'(mode_o), 4);
    wr('h0, 'h0);
    chk("R5 query exit", int'(mode_o), 0);
    wr('h55, 'h98);
    chk("R5 query from read", int'(mode_o), 4);
    wr('h55, 'hF0);
    chk("R5 query abort", int'(mode_o), 0);

    // R4 abort inside erase setup
    unlock(); wr('h555, 'h80); wr('h555, 'hF0);
    wr('h2AA, 'h55); wr('h555, 'h10);
    chk("R4 setup aborted", int'(erase_busy_o), 0);

    // R10 sector bits ignored, byte lane shift
    wrb((2048 + 'h555) << 1, 'hAA); wr('h2AA, 'h55); wr('h555, 'hA0);
    chk("R10 sector bits ignored", int'(mode_o), 2);
    wr('h40, 'hFFFF);
    wrb('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'h90);
    chk("R10 byte address shifted", int'(mode_o), 0);

    // R9 bypass
    unlock(); wr('h555, 'h20);
    chk("R9 bypass on", int'(bypass_o), 1);
    wr('h123, 'hA0);
    chk("R9 any offset", int'(mode_o), 2);
    wr('h30, 'h00FF);
    wr('h7, 'hA0); wr('h31, 'hABCD);
    wr('h8, 'hA0); wr('h901, 'h0000);
    rd('h30, v);   chk("R9 bypass program", v, 'h00FF);
    rd('h31, v);   chk("R9 back to command", v, 'hABCD);

    // R7 sector erase in bypass, R8 sector length and ignored writes
    wr('h3, 'h80); unlock();
    busy_cycles = 0;
    wr('h900, 'h30);
    wr('h555, 'hF0);
    chk("R8 write ignored busy", int'(erase_busy_o), 1);
    chk("R8 bypass kept", int'(bypass_o), 1);
    wait_erase();
    chk("R8 sector length", busy_cycles, SCYC);
    @(negedge clk);
    chk("R8 return bypass", int'(bypass_o), 1);
    rd('h901, v);  chk("R7 sector erased", v, 'hFFFF);
    rd('h10, v);   chk("R7 other sector kept", v, 'h1200);
    rd('h7FF, v);  chk("R7 edge below sector", v, 'hFFFF);

    // R9 leave bypass from autoselect with 0x00
    wr('h5, 'h90);
    chk("R9 bypass autosel", int'(mode_o), 1);
    wr('h5, 'h00);
    chk("R9 bypass exit", int'(bypass_o), 0);
    chk("R9 exit mode", int'(mode_o), 0);

    // R7 chip erase at wrong offset is rejected
    unlock(); wr('h555, 'h80); unlock(); wr('h554, 'h10);
    chk("R7 chip wrong offset", int'(erase_busy_o), 0);

    repeat (4) @(negedge clk);
    summary();
  end

endmodule